// File: doc/BRIEF.md
# Sideband Message Byte Serializer

This block takes one already-decoded link message at a time, presented as a parallel record, and plays it out over a narrow sideband one byte per clock. The record carries a 5-bit message code, a 16-bit requester ID, a 32-bit payload word, a 16-bit vendor ID and a flag saying whether a vendor message has data. The payload word does double duty: for latency-report messages its low half is the snoop latency and its high half is the no-snoop latency.

The output is a valid strobe, an 8-bit byte bus and a 5-bit code bus. The strobe stays high for a number of cycles set by the message code. The first two bytes always identify the requester, and the rest depend on the code. Records enter through a ready/valid handshake. Ready falls when a record is taken and stays low until the message has been sent and a programmable idle gap has passed. So two messages never touch and no record is lost part-way through. Codes with no meaning are taken and thrown away without any output.

Top module: `sb_msg_serializer`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_valid is 0, out_data and out_type are 0, and in_ready is 1.
- R2: A record is taken at a rising edge where in_valid and in_ready are both 1. For a defined code, out_valid rises in the next cycle and in_ready stays 0 from then until the idle gap ends.
- R3: For every defined code, the first output byte is the requester bus number in_req_id[15:8] and the second is the device/function number in_req_id[7:0].
- R4: Codes 0 to 14 (error, interrupt assert/deassert and power-management messages) and code 18 (unlock) keep out_valid high for exactly 2 cycles.
- R5: Code 15 (slot power limit) keeps out_valid high for 6 cycles. Bytes 3 to 6 are in_payload[7:0], [15:8], [23:16] and [31:24], in that order.
- R6: Code 16 (latency report) keeps out_valid high for 6 cycles. Bytes 3 and 4 are the snoop latency in_payload[15:0], low byte then high byte. Bytes 5 and 6 are the no-snoop latency in_payload[31:16], low byte then high byte.
- R7: Codes 19 and 20 (vendor messages) keep out_valid high for 4 cycles when in_has_data is 0: the two requester bytes, then in_vendor_id[7:0] and in_vendor_id[15:8]. When in_has_data is 1 they keep it high for 8 cycles, adding in_payload least significant byte first.
- R8: out_type equals the message code in every cycle out_valid is 1. out_data and out_type are 0 in every cycle out_valid is 0.
- R9: After the last valid cycle of a message, out_valid and in_ready are both 0 for exactly GAP_CYCLES cycles (GAP_CYCLES of at least 1). in_ready is 1 in the cycle after that.
- R10: A record with code 17 or 21 to 31 is taken and produces no valid cycle. in_ready is 1 again in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A record is offered |
| in_ready | output | 1 | The block can take a record |
| in_type | input | 5 | Message code of the record |
| in_req_id | input | 16 | Requester ID: bus number in [15:8], device/function number in [7:0] |
| in_payload | input | 32 | Payload word, or snoop latency [15:0] and no-snoop latency [31:16] |
| in_vendor_id | input | 16 | Vendor ID for vendor messages |
| in_has_data | input | 1 | Vendor message carries the payload word |
| out_valid | output | 1 | A message byte is on the sideband |
| out_data | output | 8 | Current message byte |
| out_type | output | 5 | Code of the message being sent |

## Verification
The bench builds the block with GAP_CYCLES set to 2 instead of the default 1. This drives the gap counter through more than one step and shows that ready comes back exactly when the gap ends and not earlier. All 32 codes are swept with both settings of the data flag. Requester, vendor and payload values are derived from the sweep index, so every byte position of every pulse length, and every reserved-code drop, is compared against arithmetic expectations.

// File: rtl/sb_msg_serializer.sv
module sb_msg_serializer #(
  parameter int GAP_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [4:0]  in_type,
  input  logic [15:0] in_req_id,
  input  logic [31:0] in_payload,
  input  logic [15:0] in_vendor_id,
  input  logic        in_has_data,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic [4:0]  out_type
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1) < 1 ? 1 : $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} state_t;

  state_t           st;
  logic [63:0]      shreg;
  logic [3:0]       left;
  logic [4:0]       type_q;
  logic [GAP_W-1:0] gap_left;

  logic [3:0]  new_len;
  logic [63:0] new_bytes;
  logic [15:0] id_bytes;
  logic        accept;

  assign id_bytes = {in_req_id[7:0], in_req_id[15:8]};
  assign accept   = in_valid && in_ready;

  always_comb begin
    new_len   = 4'd0;
    new_bytes = 64'd0;
    case (in_type) inside
      [5'd0:5'd14], 5'd18: begin
        new_len   = 4'd2;
        new_bytes = {48'd0, id_bytes};
      end
      5'd15, 5'd16: begin
        new_len   = 4'd6;
        new_bytes = {16'd0, in_payload, id_bytes};
      end
      5'd19, 5'd20: begin
        new_len   = in_has_data ? 4'd8 : 4'd4;
        new_bytes = {(in_has_data ? in_payload : 32'd0), in_vendor_id, id_bytes};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      shreg    <= '0;
      left     <= '0;
      type_q   <= '0;
      gap_left <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && new_len != 4'd0) begin
          st     <= S_SEND;
          shreg  <= new_bytes;
          left   <= new_len;
          type_q <= in_type;
        end
        S_SEND: begin
          shreg <= shreg >> 8;
          left  <= left - 4'd1;
          if (left == 4'd1) begin
            st       <= S_GAP;
            gap_left <= GAP_LOAD;
          end
        end
        S_GAP: begin
          gap_left <= gap_left - 1'b1;
          if (gap_left <= 1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_SEND);
  assign out_data  = out_valid ? shreg[7:0] : 8'd0;
  assign out_type  = out_valid ? type_q : 5'd0;
endmodule

// File: rtl/sb_msg_serializer_checker.sv
module sb_msg_serializer_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic [4:0] out_type
);
  logic [3:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= 4'd0;
    else     run <= out_valid ? run + 4'd1 : 4'd0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && in_ready));

  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_take_starts_or_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid || in_ready));

  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> (run == 4'd2 || run == 4'd4 || run == 4'd6 || run == 4'd8));

  assert_pulse_max_R7: assert property (@(posedge clk) disable iff (rst)
    run <= 4'd8);

  assert_type_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(out_type));

  assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == 8'd0 && out_type == 5'd0));

  assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> !in_ready);
endmodule

bind sb_msg_serializer sb_msg_serializer_checker u_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_type(out_type)
);

// File: tb/sb_msg_serializer_bench.sv
module sb_msg_serializer_bench;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_type = '0;
  logic [15:0] in_req_id = '0;
  logic [31:0] in_payload = '0;
  logic [15:0] in_vendor_id = '0;
  logic        in_has_data = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [4:0]  out_type;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sb_msg_serializer #(.GAP_CYCLES(GAP)) u_sb_msg_serializer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_req_id(in_req_id), .in_payload(in_payload),
    .in_vendor_id(in_vendor_id), .in_has_data(in_has_data),
    .out_valid(out_valid), .out_data(out_data), .out_type(out_type)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input logic [4:0] t, input logic h);
    if (t <= 5'd14 || t == 5'd18) return 2;
    if (t == 5'd15 || t == 5'd16) return 6;
    if (t == 5'd19 || t == 5'd20) return h ? 8 : 4;
    return 0;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [4:0] t, input int i,
      input logic [15:0] rid, input logic [31:0] pay, input logic [15:0] vid);
    if (i == 0) return rid[15:8];
    if (i == 1) return rid[7:0];
    if (t == 5'd15 || t == 5'd16) return pay[8*(i-2) +: 8];
    if (i == 2) return vid[7:0];
    if (i == 3) return vid[15:8];
    return pay[8*(i-4) +: 8];
  endfunction

  task automatic send(input logic [4:0] t, input logic h, input int seed);
    logic [15:0] rid;
    logic [31:0] pay;
    logic [15:0] vid;
    int n;
    string rq;
    rid = 16'(seed * 16'h3b1d + 16'h0a5c);
    pay = 32'(seed * 32'h9e3779b1 + 32'h01234567);
    vid = 16'(seed * 16'h71c3 + 16'h5aa5);
    n = exp_len(t, h);
    rq = (t == 5'd15) ? "R5" : (t == 5'd16) ? "R6" : (t == 5'd19 || t == 5'd20) ? "R7" : "R4";
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 ready before offer", 32'(in_ready), 1);
    in_valid = 1'b1; in_type = t; in_has_data = h;
    in_req_id = rid; in_payload = pay; in_vendor_id = vid;
    @(negedge clk);
    in_valid = 1'b0;
    in_payload = ~pay; in_req_id = ~rid; in_vendor_id = ~vid;
    if (n == 0) begin
      chk(out_valid === 1'b0, "R10 no output", 32'(out_valid), 0);
      chk(in_ready === 1'b1, "R10 ready again", 32'(in_ready), 1);
    end else begin
      for (int i = 0; i < n; i++) begin
        chk(out_valid === 1'b1, i < 2 ? "R2 valid" : rq, 32'(out_valid), 1);
        chk(out_data === exp_byte(t, i, rid, pay, vid), i < 2 ? "R3 id byte" : rq,
            32'(out_data), 32'(exp_byte(t, i, rid, pay, vid)));
        chk(out_type === t, "R8 type held", 32'(out_type), 32'(t));
        chk(in_ready === 1'b0, "R2 busy", 32'(in_ready), 0);
        @(negedge clk);
      end
      for (int g = 0; g < GAP; g++) begin
        chk(out_valid === 1'b0, {rq, " length end"}, 32'(out_valid), 0);
        chk(out_data === 8'd0 && out_type === 5'd0, "R8 quiet bus",
            {16'd0, out_data, 3'd0, out_type}, 0);
        chk(in_ready === 1'b0, "R9 gap ready low", 32'(in_ready), 0);
        @(negedge clk);
      end
      chk(in_ready === 1'b1 && out_valid === 1'b0, "R9 ready after gap",
          {30'd0, in_ready, out_valid}, 2);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_data === 8'd0 && out_type === 5'd0, "R1 reset outputs",
        {16'd0, out_data, 2'd0, out_valid, out_type}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 idle after reset",
        {30'd0, in_ready, out_valid}, 2);
    for (int h = 0; h < 2; h++)
      for (int t = 0; t < 32; t++)
        send(5'(t), h[0], t + 32 * h);
    send(5'd16, 1'b0, 99);
    send(5'd17, 1'b1, 5);
    send(5'd19, 1'b1, 7);
    finish_run();
  end
endmodule